// File: doc/BRIEF.md
# Subtractive GCD Engine

This block computes the greatest common divisor of two unsigned operands, 32 bits wide by default. It needs no divider. A datapath holds two working registers, X and Y. A two-input multiplexer feeds X. One subtractor forms X minus Y, and its sign bit serves as the X-below-Y comparison. A zero detector watches Y. Both status flags are captured in one-bit registers, and a small controller acts on those registered flags. On each step the controller swaps the operands, takes Y away from X, or finishes.

A caller waits for `ready_o`, then presents both operands with a single-cycle `start_i`. When the answer is in X, the block raises `done_o` for exactly one cycle, with the answer on `result_o`. It then returns to ready. Every decision costs two clock edges: one edge captures the flags and the next edge applies the update. The latency therefore grows with the number of subtract and swap steps the operand pair needs.

Top module: `gcd_subtract`

## Requirements
- R1: After synchronous reset, `ready_o` is 1 and `done_o` is 0.
- R2: A `start_i` sampled high while `ready_o` is 1 loads `a_i` into X and `b_i` into Y, and `ready_o` is 0 from the next cycle.
- R3: `done_o` is high for exactly one cycle. In that cycle `result_o` equals gcd(a, b), and `ready_o` is 1 in the following cycle.
- R4: When X is below Y, one update sets X to the old Y and Y to the old X.
- R5: When X is not below Y and Y is nonzero, X becomes X minus Y and Y keeps its value. Y is written only during a swap.
- R6: When Y is zero, the block finishes with the current X, so gcd(0,0)=0, gcd(a,0)=a and gcd(0,b)=b.
- R7: The below comparison is the sign bit of a subtraction one bit wider than the operands, so it is correct when operands have the top bit set.
- R8: A `start_i` that arrives while `ready_o` is 0 is ignored. The running result is unchanged and no extra `done_o` follows.
- R9: The flags are registered before the controller uses them. With Y loaded as zero, `done_o` rises 2 clock edges after the load edge, and each swap or subtract step adds 2 more edges. For example, (0,9) takes 4 edges and (7,7) takes 6 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Load operands and begin (taken only when ready) |
| a_i | input | WIDTH | First operand, loaded into X |
| b_i | input | WIDTH | Second operand, loaded into Y |
| ready_o | output | 1 | Idle and able to accept `start_i` |
| done_o | output | 1 | One-cycle result-valid strobe |
| result_o | output | WIDTH | GCD value, valid while `done_o` is high |

## Verification
The embedded assertions check the following on every cycle:
- a swap cross-loads both registers in one update;
- a subtract step leaves Y untouched and reduces X by exactly Y;
- Y holds whenever it is not enabled;
- each registered flag matches a plain comparison of the previous cycle's registers;
- Y is zero whenever `done_o` is high;
- `done_o` is a single-cycle pulse followed by ready.

Only the bench scenarios can show end-to-end correctness against an independent Euclid reference. The scenarios cover equal, zero, coprime and top-bit operands, the exact step-dependent latency, and the rejection of a start that arrives mid-computation.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_STEP  = 2'd2,
        ST_DONE  = 2'd3
    } gcd_state_e;

    typedef struct packed {
        gcd_state_e state;
    } ctrl_regs_t;

    typedef struct packed {
        logic less;
        logic yzero;
    } flag_regs_t;

endpackage

// File: rtl/gcd_datapath.sv
module gcd_datapath #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             x_en_i,
    input  logic             y_en_i,
    input  logic             sel_diff_i,
    output logic [WIDTH-1:0] x_o,
    output logic [WIDTH-1:0] y_o,
    output logic             less_o,
    output logic             yzero_o
);
    localparam int EXT_W = WIDTH + 1;

    typedef struct packed {
        logic [WIDTH-1:0] x;
        logic [WIDTH-1:0] y;
    } dp_regs_t;

    dp_regs_t         regs_d, regs_q;
    logic [EXT_W-1:0] diff_ext;
    logic [WIDTH-1:0] x_mux;

    // Widened subtractor: the extra top bit is the borrow, i.e. X below Y.
    always_comb begin
        diff_ext = {1'b0, regs_q.x} - {1'b0, regs_q.y};
        x_mux    = sel_diff_i ? diff_ext[WIDTH-1:0] : regs_q.y;
        regs_d   = regs_q;
        if (load_i) begin
            regs_d.x = a_i;
            regs_d.y = b_i;
        end else begin
            if (x_en_i) regs_d.x = x_mux;
            if (y_en_i) regs_d.y = regs_q.x;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign x_o     = regs_q.x;
    assign y_o     = regs_q.y;
    assign less_o  = diff_ext[EXT_W-1];
    assign yzero_o = (regs_q.y == '0);

    AST_SWAP_CROSS: assert property (@(posedge clk) disable iff (rst)
        (x_en_i && y_en_i && !sel_diff_i && !load_i) |=> (regs_q.x == $past(regs_q.y) && regs_q.y == $past(regs_q.x))); // R4
    AST_SUB_STEP: assert property (@(posedge clk) disable iff (rst)
        (x_en_i && !y_en_i && sel_diff_i && !load_i) |=> (regs_q.x == $past(regs_q.x) - $past(regs_q.y))); // R5
    AST_Y_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!y_en_i && !load_i) |=> $stable(regs_q.y)); // R5

endmodule

// File: rtl/gcd_flags.sv
module gcd_flags #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             less_i,
    input  logic             yzero_i,
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    output logic             less_q_o,
    output logic             yzero_q_o
);
    import gcd_pkg::*;

    flag_regs_t flags_d, flags_q;

    always_comb begin
        flags_d.less  = less_i;
        flags_d.yzero = yzero_i;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign less_q_o  = flags_q.less;
    assign yzero_q_o = flags_q.yzero;

    AST_LESS_FLAG: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (flags_q.less == ($past(x_i) < $past(y_i)))); // R7
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (flags_q.yzero == ($past(y_i) == '0))); // R9

endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic less_q_i,
    input  logic yzero_q_i,
    output logic load_o,
    output logic x_en_o,
    output logic y_en_o,
    output logic sel_diff_o,
    output logic ready_o,
    output logic done_o
);
    import gcd_pkg::*;

    ctrl_regs_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        load_o     = 1'b0;
        x_en_o     = 1'b0;
        y_en_o     = 1'b0;
        sel_diff_o = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    load_o      = 1'b1;
                    ctl_d.state = ST_CHECK;
                end
            end
            ST_CHECK: ctl_d.state = ST_STEP;
            ST_STEP: begin
                if (yzero_q_i) begin
                    ctl_d.state = ST_DONE;
                end else begin
                    x_en_o      = 1'b1;
                    y_en_o      = less_q_i;
                    sel_diff_o  = !less_q_i;
                    ctl_d.state = ST_CHECK;
                end
            end
            ST_DONE: ctl_d.state = ST_IDLE;
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q.state <= ST_IDLE;
        else     ctl_q       <= ctl_d;
    end

    assign ready_o = (ctl_q.state == ST_IDLE);
    assign done_o  = (ctl_q.state == ST_DONE);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && ready_o)); // R3
    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && !done_o && start_i) |=> !ready_o); // R8

endmodule

// File: rtl/gcd_subtract.sv
module gcd_subtract #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             ready_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);
    logic             load, x_en, y_en, sel_diff;
    logic             less_c, yzero_c, less_q, yzero_q;
    logic [WIDTH-1:0] x_val, y_val;

    gcd_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .a_i        (a_i),
        .b_i        (b_i),
        .x_en_i     (x_en),
        .y_en_i     (y_en),
        .sel_diff_i (sel_diff),
        .x_o        (x_val),
        .y_o        (y_val),
        .less_o     (less_c),
        .yzero_o    (yzero_c)
    );

    gcd_flags #(.WIDTH(WIDTH)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .less_i    (less_c),
        .yzero_i   (yzero_c),
        .x_i       (x_val),
        .y_i       (y_val),
        .less_q_o  (less_q),
        .yzero_q_o (yzero_q)
    );

    gcd_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .less_q_i   (less_q),
        .yzero_q_i  (yzero_q),
        .load_o     (load),
        .x_en_o     (x_en),
        .y_en_o     (y_en),
        .sel_diff_o (sel_diff),
        .ready_o    (ready_o),
        .done_o     (done_o)
    );

    assign result_o = x_val;

    AST_DONE_YZERO: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (y_val == '0)); // R6
    AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (ready_o && start_i) |=> (!ready_o && x_val == $past(a_i) && y_val == $past(b_i))); // R2

endmodule

// File: tb/gcd_subtract_test.sv
`timescale 1ns/1ps
module gcd_subtract_test;
    localparam int W     = 32;
    localparam int NVEC  = 14;
    localparam int LIMIT = 20000;

    // {a, b, expected gcd}
    localparam logic [3*W-1:0] VEC [NVEC] = '{
        {32'd12,         32'd18,         32'd6},
        {32'd18,         32'd12,         32'd6},
        {32'd7,          32'd7,          32'd7},
        {32'd0,          32'd9,          32'd9},
        {32'd9,          32'd0,          32'd9},
        {32'd0,          32'd0,          32'd0},
        {32'd1,          32'd5000,       32'd1},
        {32'd5000,       32'd1,          32'd1},
        {32'd17,         32'd13,         32'd1},
        {32'hF000_0000,  32'h1000_0000,  32'h1000_0000},
        {32'hC000_0000,  32'h8000_0000,  32'h4000_0000},
        {32'hFFFF_FFFF,  32'hFFFF_FFFF,  32'hFFFF_FFFF},
        {32'd1071,       32'd462,        32'd21},
        {32'd4096,       32'd1024,       32'd1024}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [W-1:0] a_i = '0, b_i = '0;
    logic         ready_o, done_o;
    logic [W-1:0] result_o;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;

    gcd_subtract #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .a_i(a_i), .b_i(b_i),
        .ready_o(ready_o), .done_o(done_o), .result_o(result_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        edges <= edges + 1;
        if (edges > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run exceeded cycle budget, actual=%0d expected<=190000", edges);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    function automatic logic [W-1:0] euclid(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] p = a, q = b, t;
        while (q != 0) begin
            t = p % q;
            p = q;
            q = t;
        end
        return p;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Runs one operation; inject=1 pulses a second start while busy.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit inject,
                          output logic [W-1:0] res, output int cyc);
        @(negedge clk);
        a_i = a; b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        check("R2 ready low after load", {31'd0, ready_o}, 32'd0);
        if (inject) begin
            a_i = 32'd100; b_i = 32'd75; start_i = 1'b1;
            @(negedge clk);
            cyc++;
            start_i = 1'b0;
        end
        while (!done_o && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
        end
        res = result_o;
        if (!done_o) check("R3 done reached", 32'd0, 32'd1);
        @(negedge clk);
        check("R3 done one cycle", {31'd0, done_o}, 32'd0);
        check("R3 ready after done", {31'd0, ready_o}, 32'd1);
    endtask

    initial begin
        logic [W-1:0] res;
        int cyc;

        repeat (3) @(negedge clk);
        check("R1 ready in reset state", {31'd0, ready_o}, 32'd1);
        check("R1 done low in reset", {31'd0, done_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", {31'd0, ready_o}, 32'd1);

        // R3 R4 R5 R6 R7: table walk against expected and Euclid reference
        for (int i = 0; i < NVEC; i++) begin
            logic [W-1:0] va, vb, vg;
            {va, vb, vg} = VEC[i];
            run_op(va, vb, 1'b0, res, cyc);
            check("R3 table result", res, vg);
            check("R7 euclid agreement", res, euclid(va, vb));
        end

        // R9 latency: flags registered, two edges per decision
        run_op(32'd9, 32'd0, 1'b0, res, cyc);
        check("R9 latency y zero", cyc, 32'd2);
        check("R6 gcd(9,0)", res, 32'd9);
        run_op(32'd0, 32'd9, 1'b0, res, cyc);
        check("R9 R4 latency one swap", cyc, 32'd4);
        run_op(32'd7, 32'd7, 1'b0, res, cyc);
        check("R9 R5 latency subtract then swap", cyc, 32'd6);

        // R8: start while busy is ignored
        run_op(32'd48, 32'd18, 1'b1, res, cyc);
        check("R8 busy start ignored result", res, 32'd6);
        begin
            int extra = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (done_o) extra++;
            end
            check("R8 no extra done", extra, 32'd0);
        end

        // R3: random 12-bit pairs
        for (int i = 0; i < 8; i++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom() % 4096;
            rb = $urandom() % 4096;
            run_op(ra, rb, 1'b0, res, cyc);
            check("R3 random pair", res, euclid(ra, rb));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule